// File: doc/BRIEF.md
# Lane Drive Setting Merger

This block turns the drive adjustment requests that a DisplayPort receiver reports for each lane into one shared drive setting, which the transmitter then applies to every active lane. Each lane asks for a voltage-swing level and a pre-emphasis level of two bits each. The block takes the highest swing request and the highest pre-emphasis request among the active lanes. It limits the swing to level 2. It then limits the pre-emphasis to a ceiling that depends on the swing that was chosen. Whenever a limit is applied, the block sets a flag inside the training byte.

A training sequencer pulses the update strobe once for each status poll and reads the lane bytes back when the valid pulse arrives. It pulses the clear strobe at the start of a training attempt, which puts every lane back to the lowest drive. The all-lanes-at-maximum-swing output lets the sequencer see that raising the swing further would achieve nothing.

Top module: `lane_drive_merge`

## Requirements
- R1: After reset, every lane byte is 0x00 and setValid and allMaxSwing are low.
- R2: On an applied update, the chosen swing is the largest swing request among the active lanes. Requests from inactive lanes have no effect. Lane i uses swingReq[2i+1:2i].
- R3: If the chosen swing is 2 or more, the block writes swing 2 and sets the max-swing flag (bit 2). Otherwise the flag is 0.
- R4: The pre-emphasis ceiling is 3, 2 or 1 for a final swing of 0, 1 or 2. If the chosen pre-emphasis is at or above the ceiling, the block writes the ceiling and sets the max-pre-emphasis flag (bit 5). Otherwise the flag is 0.
- R5: The chosen pre-emphasis is the largest pre-emphasis request among the active lanes. Lane i uses preReq[2i+1:2i].
- R6: Training byte layout: bits [1:0] hold the swing, bit 2 the max-swing flag, bits [4:3] the pre-emphasis and bit 5 the max-pre-emphasis flag. Bits [7:6] are always 0. Lane i occupies trainSet[8i+7:8i].
- R7: An update writes the same byte to every active lane. Lanes beyond the active count keep their previous byte.
- R8: laneCode selects the active lanes: 0 selects lane 0 only, 1 selects lanes 0 and 1, and 2 or 3 selects all four lanes.
- R9: The lane bytes change on the first clock edge after an update strobe. setValid is high for exactly that one following cycle and is low otherwise.
- R10: A clear strobe sets all four lane bytes to 0x00 at the next edge, whatever laneCode is. A clear takes precedence over an update in the same cycle, and that update then produces no setValid pulse.
- R11: allMaxSwing is high exactly when every active lane's byte has its max-swing flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| updStb | input | 1 | Apply the current requests |
| clrStb | input | 1 | Set all lane bytes to zero |
| laneCode | input | 2 | Active lane count code (R8) |
| swingReq | input | 8 | Swing requests, 2 bits per lane |
| preReq | input | 8 | Pre-emphasis requests, 2 bits per lane |
| trainSet | output | 32 | Registered training byte per lane |
| allMaxSwing | output | 1 | Every active lane is at its maximum swing |
| setValid | output | 1 | One-cycle pulse after an applied update |

## Verification
The clear and the update can be requested in the same cycle, and they compete for the same lane registers. The bench asserts both strobes together on a clock edge while the lanes hold nonzero bytes and the requests would produce a different nonzero byte. The result is judged correct only if every lane reads 0x00 afterwards and setValid stays low. The bench then runs a normal update and checks that it still takes effect, which shows that the dropped update left no trace behind.

// File: rtl/lane_drive_pkg.sv
package lane_drive_pkg;

  localparam int REQ_W  = 2;
  localparam int BYTE_W = 8;
  localparam logic [REQ_W-1:0] SWING_CAP = 2'd2;

  typedef struct packed {
    logic doClr;
    logic doUpd;
  } laneStrobe_t;

  typedef struct packed {
    logic [1:0]       pad;
    logic             preMax;
    logic [REQ_W-1:0] pre;
    logic             swMax;
    logic [REQ_W-1:0] swing;
  } trainByte_t;

  function automatic logic [REQ_W-1:0] preCeil(input logic [REQ_W-1:0] sw);
    case (sw)
      2'd0:    preCeil = 2'd3;
      2'd1:    preCeil = 2'd2;
      2'd2:    preCeil = 2'd1;
      default: preCeil = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/lane_drive_ctrl.sv
module lane_drive_ctrl
  import lane_drive_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             updStb,
  input  logic             clrStb,
  input  logic [1:0]       laneCode,
  output laneStrobe_t      stb,
  output logic [LANES-1:0] laneMask,
  output logic             setValid
);

  int activeCnt;

  // Clear wins over update (R10).
  always_comb begin
    stb.doClr = clrStb;
    stb.doUpd = updStb && !clrStb;
  end

  // Active lane count decode (R8).
  always_comb begin
    case (laneCode)
      2'd0:    activeCnt = 1;
      2'd1:    activeCnt = 2;
      default: activeCnt = LANES;
    endcase
    for (int i = 0; i < LANES; i++) begin
      laneMask[i] = (i < activeCnt);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) setValid <= 1'b0;
    else       setValid <= stb.doUpd;
  end

  p_valid_after_upd_r9: assert property (@(posedge clk) disable iff (!rstN)
    (updStb && !clrStb) |=> setValid);
  p_clear_no_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    clrStb |=> !setValid);
  p_lane0_active_r8: assert property (@(posedge clk) disable iff (!rstN)
    laneMask[0]);

endmodule

// File: rtl/lane_drive_dp.sv
module lane_drive_dp
  import lane_drive_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  laneStrobe_t             stb,
  input  logic [LANES-1:0]        laneMask,
  input  logic [LANES*REQ_W-1:0]  swingReq,
  input  logic [LANES*REQ_W-1:0]  preReq,
  output logic [LANES*BYTE_W-1:0] trainSet,
  output logic                    allMaxSwing
);

  logic [REQ_W-1:0] swMerged, peMerged;
  logic [REQ_W-1:0] swFinal, peFinal, ceilNow;
  logic             swHit, peHit;
  trainByte_t       nextByte;
  trainByte_t       laneQ [LANES];
  logic [LANES-1:0] swFlagVec;

  // Maximum over active lanes (R2, R5).
  always_comb begin
    swMerged = '0;
    peMerged = '0;
    for (int i = 0; i < LANES; i++) begin
      if (laneMask[i] && swingReq[i*REQ_W +: REQ_W] > swMerged)
        swMerged = swingReq[i*REQ_W +: REQ_W];
      if (laneMask[i] && preReq[i*REQ_W +: REQ_W] > peMerged)
        peMerged = preReq[i*REQ_W +: REQ_W];
    end
  end

  // Swing cap then swing-dependent pre-emphasis ceiling (R3, R4).
  always_comb begin
    swHit   = (swMerged >= SWING_CAP);
    swFinal = swHit ? SWING_CAP : swMerged;
    ceilNow = preCeil(swFinal);
    peHit   = (peMerged >= ceilNow);
    peFinal = peHit ? ceilNow : peMerged;
    nextByte.pad    = 2'b00;
    nextByte.preMax = peHit;
    nextByte.pre    = peFinal;
    nextByte.swMax  = swHit;
    nextByte.swing  = swFinal;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         laneQ[g] <= '0;
      else if (stb.doClr)                laneQ[g] <= '0;
      else if (stb.doUpd && laneMask[g]) laneQ[g] <= nextByte;
    end

    assign trainSet[g*BYTE_W +: BYTE_W] = laneQ[g];
    assign swFlagVec[g] = laneQ[g].swMax | ~laneMask[g];

    p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
      laneQ[g].pad == 2'b00);
    p_swing_capped_r3: assert property (@(posedge clk) disable iff (!rstN)
      laneQ[g].swing <= SWING_CAP && (laneQ[g].swMax == (laneQ[g].swing == SWING_CAP)));
    p_pre_ceiling_r4: assert property (@(posedge clk) disable iff (!rstN)
      laneQ[g].pre <= preCeil(laneQ[g].swing));
    p_idle_lane_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
      (!laneMask[g] && !stb.doClr) |=> $stable(laneQ[g]));
    p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
      stb.doClr |=> (laneQ[g] == '0));
  end

  assign allMaxSwing = &swFlagVec;

  p_lanes_match_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doUpd && !stb.doClr && laneMask[LANES-1]) |=> (laneQ[LANES-1] == laneQ[0]));

endmodule

// File: rtl/lane_drive_merge.sv
module lane_drive_merge
  import lane_drive_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    updStb,
  input  logic                    clrStb,
  input  logic [1:0]              laneCode,
  input  logic [LANES*REQ_W-1:0]  swingReq,
  input  logic [LANES*REQ_W-1:0]  preReq,
  output logic [LANES*BYTE_W-1:0] trainSet,
  output logic                    allMaxSwing,
  output logic                    setValid
);

  laneStrobe_t      stb;
  logic [LANES-1:0] laneMask;

  lane_drive_ctrl #(.LANES(LANES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .updStb   (updStb),
    .clrStb   (clrStb),
    .laneCode (laneCode),
    .stb      (stb),
    .laneMask (laneMask),
    .setValid (setValid)
  );

  lane_drive_dp #(.LANES(LANES)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .laneMask    (laneMask),
    .swingReq    (swingReq),
    .preReq      (preReq),
    .trainSet    (trainSet),
    .allMaxSwing (allMaxSwing)
  );

endmodule

// File: tb/sim_lane_drive_merge.sv
module sim_lane_drive_merge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        updStb = 1'b0, clrStb = 1'b0;
  logic [1:0]  laneCode = 2'd2;
  logic [7:0]  swingReq = '0, preReq = '0;
  logic [31:0] trainSet;
  logic        allMaxSwing, setValid;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] expLane [4];
  bit done = 0;

  always #10 clk = ~clk;

  lane_drive_merge u0 (
    .clk(clk), .rstN(rstN), .updStb(updStb), .clrStb(clrStb),
    .laneCode(laneCode), .swingReq(swingReq), .preReq(preReq),
    .trainSet(trainSet), .allMaxSwing(allMaxSwing), .setValid(setValid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nAct(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] expVec();
    return {expLane[3], expLane[2], expLane[1], expLane[0]};
  endfunction

  function automatic logic expAllMax(input logic [1:0] c);
    logic r = 1'b1;
    for (int i = 0; i < nAct(c); i++) r &= expLane[i][2];
    return r;
  endfunction

  // Reference byte: max, cap swing at 2, ceiling = 3 - swing.
  function automatic logic [7:0] refByte(input logic [1:0] c, input logic [7:0] sw, input logic [7:0] pe);
    int v = 0, p = 0, cl, vf = 0, pf = 0;
    for (int i = 0; i < nAct(c); i++) begin
      if (int'(sw[2*i +: 2]) > v) v = int'(sw[2*i +: 2]);
      if (int'(pe[2*i +: 2]) > p) p = int'(pe[2*i +: 2]);
    end
    if (v >= 2) begin v = 2; vf = 1; end
    cl = 3 - v;
    if (p >= cl) begin p = cl; pf = 1; end
    return 8'(pf * 32 + p * 8 + vf * 4 + v);
  endfunction

  task automatic doUpdate(input logic [1:0] c, input logic [7:0] sw, input logic [7:0] pe);
    logic [7:0] b;
    @(negedge clk);
    check("R9 valid low between updates", {31'd0, setValid}, 32'd0);
    laneCode = c; swingReq = sw; preReq = pe; updStb = 1'b1;
    b = refByte(c, sw, pe);
    for (int i = 0; i < nAct(c); i++) expLane[i] = b;
    @(negedge clk);
    updStb = 1'b0;
    check("R2 R3 R4 R5 R6 R7 R8 lane bytes", trainSet, expVec());
    check("R9 valid pulse", {31'd0, setValid}, 32'd1);
    check("R11 all max swing", {31'd0, allMaxSwing}, {31'd0, expAllMax(c)});
  endtask

  task automatic doClear(input logic withUpd);
    @(negedge clk);
    laneCode = 2'd0; swingReq = 8'hFF; preReq = 8'h55;
    clrStb = 1'b1; updStb = withUpd;
    for (int i = 0; i < 4; i++) expLane[i] = 8'h00;
    @(negedge clk);
    clrStb = 1'b0; updStb = 1'b0;
    check("R10 clear zeros all lanes", trainSet, 32'd0);
    check("R10 no valid on clear", {31'd0, setValid}, 32'd0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) expLane[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 reset bytes", trainSet, 32'd0);
    check("R1 reset valid", {31'd0, setValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 bytes after release", trainSet, 32'd0);
    check("R1 R11 allMaxSwing low", {31'd0, allMaxSwing}, 32'd0);

    // Four lanes: spread pattern plus both extremes.
    doUpdate(2'd2, 8'h00, 8'h00);
    doUpdate(2'd3, 8'hFF, 8'hFF);
    for (int k = 0; k < 1024; k++) begin
      logic [15:0] pat = 16'(k * 40503 + 7);
      doUpdate((k % 2 == 0) ? 2'd2 : 2'd3, pat[7:0], pat[15:8]);
    end
    // Two lanes exhaustive; inactive request bits driven high (R7 R8).
    for (int k = 0; k < 256; k++) begin
      logic [7:0] kk = 8'(k);
      doUpdate(2'd1, {4'hF, kk[3:0]}, {4'hF, kk[7:4]});
    end
    // One lane exhaustive.
    for (int k = 0; k < 16; k++) begin
      logic [3:0] kk = 4'(k);
      doUpdate(2'd0, {6'h3F, kk[1:0]}, {6'h3F, kk[3:2]});
    end
    // Lane 0 at max swing, upper lanes held from earlier: R11 per count.
    doClear(1'b0);
    doUpdate(2'd0, 8'h02, 8'h00);
    check("R11 one lane at max", {31'd0, allMaxSwing}, 32'd1);
    laneCode = 2'd2;
    @(negedge clk);
    check("R11 idle lanes not at max", {31'd0, allMaxSwing}, 32'd0);
    // Clear together with update, then normal update works again.
    doUpdate(2'd2, 8'h55, 8'h00);
    doClear(1'b1);
    doUpdate(2'd2, 8'h01, 8'h03);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    done = 1;
    $finish;
  end

endmodule